// File: doc/BRIEF.md
# Base Address Window Size Probe

This block is a host-side sequencer that finds out how much address space one base address register of a device asks for. It reaches the register through a configuration access port. A single start pulse names the target register. The engine then steps through a fixed order of accesses. It first saves the live value, then writes all ones, then reads the result back, and finally puts the saved value back. Only after that does it report the decoded window with a one-cycle done pulse.

The low bit of the saved value decides between a memory window and an I/O window. A memory window whose type field marks it as 64-bit makes the engine handle the register and its upper neighbour as one pair. Each step then touches both halves. The size comes from the read-back: the information bits are cleared, the value is inverted, and one is added. A register that reads back as zero after the all-ones write is reported as unimplemented, with size zero.

The configuration port is a request/acknowledge stream. The engine raises `cfg_req_o` and holds the write flag, index and write data stable until it samples `cfg_ack_i` high on a rising edge. The responder may stall for any number of cycles by keeping the acknowledge low. Read data is taken in the same cycle as the acknowledge. No new access starts before the current one is acknowledged. Start and done are plain control pins.

Top module: `bar_size_probe`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `cfg_req_o` are low.
- R2: For a 32-bit window at index N the engine makes exactly four accesses, in this order: read N, write all ones to N, read N, write the saved value to N.
- R3: When the saved value has bit 0 = 0 and bits 2:1 = 2'b10, the engine treats N and N+1 as a pair. It makes eight accesses in this order: read N, read N+1, write ones to N, write ones to N+1, read N, read N+1, restore N, restore N+1. It also sets `is_64_o`.
- R4: For a memory window (saved bit 0 = 0), `size_o` is the bitwise NOT of the 64-bit mask, plus one. The mask's low word is the read-back with bits 3:0 cleared. Its high word is the N+1 read-back for a pair, and all ones otherwise.
- R5: For an I/O window (saved bit 0 = 1), `is_io_o` is set. The mask is the read-back with bits 1:0 cleared and bits 31:16 forced to one, with all ones above bit 31. `size_o` is NOT mask plus one.
- R6: If the low read-back after the all-ones write is zero, `unimpl_o` is set and `size_o` is zero.
- R7: While `cfg_req_o` is high and `cfg_ack_i` is low, the request and its write flag, index and write data stay unchanged in the next cycle.
- R8: `done_o` is high for exactly one cycle. By then the saved value(s) have been written back. The results stay valid until the next accepted start.
- R9: A start pulse while `busy_o` is high is ignored: the run in progress keeps its index, and no second run follows.
- R10: Whenever `done_o` is high, `size_o` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_idx_i | input | IDX_W | Index of the register to probe |
| cfg_req_o | output | 1 | Access request (valid) |
| cfg_we_o | output | 1 | 1 = write, 0 = read |
| cfg_idx_o | output | IDX_W | Register index of the access |
| cfg_wdata_o | output | DW | Write data |
| cfg_ack_i | input | 1 | Access acknowledge (ready) |
| cfg_rdata_i | input | DW | Read data, valid with the acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High from the accepted start through done |
| size_o | output | 2*DW | Window size in bytes |
| is_io_o | output | 1 | Window is I/O space |
| is_64_o | output | 1 | Window is a 64-bit pair |
| unimpl_o | output | 1 | Register is not implemented |

## Verification
`cfg_req_o` goes high in the cycle after the edge that accepts a start. Each access ends on the first rising edge where the acknowledge is high. `done_o` is high only in the cycle after the edge that takes the last restore acknowledge. The bench answers requests at the falling edge after a set number of stall cycles. It logs every handshake at the rising edge, and checks outputs and the model's register contents at the falling edge of the `done_o` cycle, so each result is read exactly when it is due. One test fires a second start at the falling edge a few cycles into a run. It then watches the following idle cycles for a stray request.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE_LO,
    ST_SAVE_HI,
    ST_ONES_LO,
    ST_ONES_HI,
    ST_READ_LO,
    ST_READ_HI,
    ST_REST_LO,
    ST_REST_HI,
    ST_DONE
  } probe_st_e;

endpackage

// File: rtl/bsp_seq.sv
module bsp_seq
  import bsp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  output logic             cfg_req_o,
  output logic             cfg_we_o,
  output logic [IDX_W-1:0] cfg_idx_o,
  output logic [DW-1:0]    cfg_wdata_o,
  input  logic             cfg_ack_i,
  input  logic [DW-1:0]    cfg_rdata_i,
  output logic [DW-1:0]    rb_lo_o,
  output logic [DW-1:0]    rb_hi_o,
  output logic             is_io_o,
  output logic             is_64_o,
  output logic             done_o,
  output logic             busy_o
);

  localparam logic [1:0] PAIR_CODE = 2'b10;

  probe_st_e            st_q;
  logic [IDX_W-1:0]     tgt_q;
  logic [DW-1:0]        save_lo_q, save_hi_q;
  logic [DW-1:0]        rb_lo_q, rb_hi_q;
  logic                 io_q, pair_q;
  logic                 rd_is_pair;

  assign rd_is_pair = !cfg_rdata_i[0] && (cfg_rdata_i[2:1] == PAIR_CODE);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      tgt_q     <= '0;
      save_lo_q <= '0;
      save_hi_q <= '0;
      rb_lo_q   <= '0;
      rb_hi_q   <= '0;
      io_q      <= 1'b0;
      pair_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          tgt_q <= start_idx_i;
          st_q  <= ST_SAVE_LO;
        end
        ST_SAVE_LO: if (cfg_ack_i) begin
          save_lo_q <= cfg_rdata_i;
          io_q      <= cfg_rdata_i[0];
          pair_q    <= rd_is_pair;
          st_q      <= rd_is_pair ? ST_SAVE_HI : ST_ONES_LO;
        end
        ST_SAVE_HI: if (cfg_ack_i) begin
          save_hi_q <= cfg_rdata_i;
          st_q      <= ST_ONES_LO;
        end
        ST_ONES_LO: if (cfg_ack_i) st_q <= pair_q ? ST_ONES_HI : ST_READ_LO;
        ST_ONES_HI: if (cfg_ack_i) st_q <= ST_READ_LO;
        ST_READ_LO: if (cfg_ack_i) begin
          rb_lo_q <= cfg_rdata_i;
          st_q    <= pair_q ? ST_READ_HI : ST_REST_LO;
        end
        ST_READ_HI: if (cfg_ack_i) begin
          rb_hi_q <= cfg_rdata_i;
          st_q    <= ST_REST_LO;
        end
        ST_REST_LO: if (cfg_ack_i) st_q <= pair_q ? ST_REST_HI : ST_DONE;
        ST_REST_HI: if (cfg_ack_i) st_q <= ST_DONE;
        ST_DONE:    st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cfg_req_o   = (st_q != ST_IDLE) && (st_q != ST_DONE);
    cfg_we_o    = (st_q == ST_ONES_LO) || (st_q == ST_ONES_HI) ||
                  (st_q == ST_REST_LO) || (st_q == ST_REST_HI);
    cfg_idx_o   = ((st_q == ST_SAVE_HI) || (st_q == ST_ONES_HI) ||
                   (st_q == ST_READ_HI) || (st_q == ST_REST_HI))
                  ? tgt_q + IDX_W'(1) : tgt_q;
    cfg_wdata_o = '0;
    if ((st_q == ST_ONES_LO) || (st_q == ST_ONES_HI)) cfg_wdata_o = '1;
    else if (st_q == ST_REST_LO)                      cfg_wdata_o = save_lo_q;
    else if (st_q == ST_REST_HI)                      cfg_wdata_o = save_hi_q;
  end

  assign rb_lo_o = rb_lo_q;
  assign rb_hi_o = rb_hi_q;
  assign is_io_o = io_q;
  assign is_64_o = pair_q;
  assign done_o  = (st_q == ST_DONE);
  assign busy_o  = (st_q != ST_IDLE);

  // R7: a pending request is held with stable fields until acknowledged
  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_we_o) &&
      $stable(cfg_idx_o) && $stable(cfg_wdata_o));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: a start while busy does not change the probed index
  a_r9_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(tgt_q));

  // R8: the last access before done is a write
  a_r8_restore_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i && !cfg_we_o |=> !done_o);

endmodule

// File: rtl/bsp_size_calc.sv
module bsp_size_calc #(
  parameter int DW         = 32,
  parameter int MEM_INFO_W = 4,
  parameter int IO_INFO_W  = 2,
  parameter int IO_UP_W    = 16
) (
  input  logic [DW-1:0]   rb_lo_i,
  input  logic [DW-1:0]   rb_hi_i,
  input  logic            is_io_i,
  input  logic            is_64_i,
  output logic [2*DW-1:0] size_o,
  output logic            unimpl_o
);

  localparam int SW = 2 * DW;
  localparam logic [DW-1:0] MEM_KEEP = {{(DW-MEM_INFO_W){1'b1}}, {MEM_INFO_W{1'b0}}};
  localparam logic [DW-1:0] IO_KEEP  = {{(DW-IO_INFO_W){1'b1}}, {IO_INFO_W{1'b0}}};

  logic [DW-1:0] lo_mask, hi_mask, io_ext;
  logic [SW-1:0] full_mask;

  always_comb begin
    io_ext    = {{IO_UP_W{1'b1}}, rb_lo_i[DW-IO_UP_W-1:0]};
    lo_mask   = is_io_i ? (io_ext & IO_KEEP) : (rb_lo_i & MEM_KEEP);
    hi_mask   = is_64_i ? rb_hi_i : '1;
    full_mask = {hi_mask, lo_mask};
    unimpl_o  = (rb_lo_i == '0);
    size_o    = unimpl_o ? '0 : (~full_mask + SW'(1));
  end

endmodule

// File: rtl/bar_size_probe.sv
module bar_size_probe #(
  parameter int DW         = 32,
  parameter int IDX_W      = 3,
  parameter int MEM_INFO_W = 4,
  parameter int IO_INFO_W  = 2,
  parameter int IO_UP_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [IDX_W-1:0]  cfg_idx_o,
  output logic [DW-1:0]     cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic [DW-1:0]     cfg_rdata_i,
  output logic              done_o,
  output logic              busy_o,
  output logic [2*DW-1:0]   size_o,
  output logic              is_io_o,
  output logic              is_64_o,
  output logic              unimpl_o
);

  logic [DW-1:0] rb_lo, rb_hi;

  bsp_seq #(.DW(DW), .IDX_W(IDX_W)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_idx_i (start_idx_i),
    .cfg_req_o   (cfg_req_o),
    .cfg_we_o    (cfg_we_o),
    .cfg_idx_o   (cfg_idx_o),
    .cfg_wdata_o (cfg_wdata_o),
    .cfg_ack_i   (cfg_ack_i),
    .cfg_rdata_i (cfg_rdata_i),
    .rb_lo_o     (rb_lo),
    .rb_hi_o     (rb_hi),
    .is_io_o     (is_io_o),
    .is_64_o     (is_64_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  bsp_size_calc #(
    .DW(DW), .MEM_INFO_W(MEM_INFO_W), .IO_INFO_W(IO_INFO_W), .IO_UP_W(IO_UP_W)
  ) calc_i (
    .rb_lo_i  (rb_lo),
    .rb_hi_i  (rb_hi),
    .is_io_i  (is_io_o),
    .is_64_i  (is_64_o),
    .size_o   (size_o),
    .unimpl_o (unimpl_o)
  );

  // R10: a reported size is a power of two or zero
  a_r10_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones(size_o) <= 1);

  // R6: an unimplemented register reports size zero
  a_r6_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && unimpl_o |-> size_o == '0);

  // R5: an I/O window never forms a 64-bit pair
  a_r5_io_not_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && is_io_o |-> !is_64_o);

  // R1: no access request while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cfg_req_o && !done_o);

endmodule

// File: tb/bar_size_probe_tb_top.sv
`timescale 1ns/1ps
module bar_size_probe_tb_top;

  localparam int DW = 32;
  localparam int IW = 3;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] start_idx = '0;
  logic          cfg_req, cfg_we, cfg_ack;
  logic [IW-1:0] cfg_idx;
  logic [DW-1:0] cfg_wdata, cfg_rdata;
  logic          done, busy, is_io, is_64, unimpl;
  logic [63:0]   size;

  always #2 clk = ~clk;

  bar_size_probe dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_idx_i(start_idx),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_idx_o(cfg_idx),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .done_o(done), .busy_o(busy), .size_o(size), .is_io_o(is_io),
    .is_64_o(is_64), .unimpl_o(unimpl)
  );

  // device register model
  logic [DW-1:0] bar_val [NR];
  logic [DW-1:0] bar_init[NR];
  logic [DW-1:0] bar_wm  [NR];
  logic [DW-1:0] bar_fix [NR];
  int lat = 0;
  int wait_cnt = 0;

  logic          lg_we  [16];
  logic [IW-1:0] lg_idx [16];
  logic [DW-1:0] lg_dat [16];
  int n_log = 0;

  int n_chk = 0, n_fail = 0;
  int viol = 0;
  int cyc = 0;
  logic          pend = 1'b0;
  logic          pend_we;
  logic [IW-1:0] pend_idx;
  logic [DW-1:0] pend_wd;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic init_model();
    bar_init[0] = 32'hF800_0000; bar_wm[0] = 32'hFF00_0000; bar_fix[0] = 32'h0;
    bar_init[1] = 32'hA000_000C; bar_wm[1] = 32'hF000_0000; bar_fix[1] = 32'hC;
    bar_init[2] = 32'h0000_0000; bar_wm[2] = 32'hFFFF_FFFF; bar_fix[2] = 32'h0;
    bar_init[3] = 32'h0000_D001; bar_wm[3] = 32'h0000_FF80; bar_fix[3] = 32'h1;
    bar_init[4] = 32'h0000_0000; bar_wm[4] = 32'h0;         bar_fix[4] = 32'h0;
    bar_init[5] = 32'h0000_000C; bar_wm[5] = 32'h0;         bar_fix[5] = 32'hC;
    bar_init[6] = 32'h0000_0004; bar_wm[6] = 32'hFFFF_FFFE; bar_fix[6] = 32'h0;
    bar_init[7] = 32'h0;         bar_wm[7] = 32'h0;         bar_fix[7] = 32'h0;
    for (int i = 0; i < NR; i++) bar_val[i] = bar_init[i];
  endtask

  // responder: acknowledge after lat stall cycles, one cycle wide
  always @(negedge clk) begin
    if (cfg_req && !cfg_ack) begin
      if (wait_cnt >= lat) begin
        cfg_ack   = 1'b1;
        cfg_rdata = bar_val[cfg_idx];
        wait_cnt  = 0;
      end else wait_cnt++;
    end else begin
      cfg_ack  = 1'b0;
      wait_cnt = 0;
    end
  end

  // handshake logger, register write, hold monitor
  always @(posedge clk) begin
    cyc++;
    if (pend && (!cfg_req || cfg_we != pend_we || cfg_idx != pend_idx ||
                 cfg_wdata != pend_wd)) viol++;
    pend     = cfg_req && !cfg_ack;
    pend_we  = cfg_we;
    pend_idx = cfg_idx;
    pend_wd  = cfg_wdata;
    if (cfg_req && cfg_ack) begin
      if (n_log < 16) begin
        lg_we[n_log]  = cfg_we;
        lg_idx[n_log] = cfg_idx;
        lg_dat[n_log] = cfg_wdata;
      end
      n_log++;
      if (cfg_we) bar_val[cfg_idx] = (cfg_wdata & bar_wm[cfg_idx]) | bar_fix[cfg_idx];
    end
  end

  initial begin
    wait (cyc > 100000);
    chk(1'b0, "R8 watchdog", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_probe(input int idx, input int l);
    lat   = l;
    n_log = 0;
    @(negedge clk);
    start = 1'b1; start_idx = IW'(idx);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 300 && !done; i++) @(negedge clk);
  endtask

  task automatic chk_log(input int k, input bit we, input int idx,
                         input logic [DW-1:0] d, input string tag);
    chk(lg_we[k] == we && lg_idx[k] == IW'(idx) && (!we || lg_dat[k] == d),
        tag, {31'h0, lg_we[k], lg_idx[k], lg_dat[k]}, {31'h0, we, IW'(idx), d});
  endtask

  task automatic t_reset();
    chk(!done && !busy && !cfg_req, "R1 reset quiet", {done, busy, cfg_req}, 0);
  endtask

  task automatic t_mem32();
    run_probe(0, 0);
    chk(done, "R8 done seen", done, 1);
    chk(size == 64'h0100_0000 && !is_io && !is_64 && !unimpl, "R4 mem32 size",
        size, 64'h0100_0000);
    chk(n_log == 4, "R2 access count", n_log, 4);
    chk_log(0, 0, 0, 0, "R2 step0 read");
    chk_log(1, 1, 0, 32'hFFFF_FFFF, "R2 step1 ones");
    chk_log(2, 0, 0, 0, "R2 step2 readback");
    chk_log(3, 1, 0, 32'hF800_0000, "R2 step3 restore");
    chk(bar_val[0] == bar_init[0], "R8 restored at done", bar_val[0], bar_init[0]);
    @(negedge clk);
    chk(!done && size == 64'h0100_0000, "R8 pulse one cycle, result held",
        {done, size[62:0]}, 64'h0100_0000);
  endtask

  task automatic t_mem64();
    run_probe(1, 2);
    chk(size == 64'h1000_0000 && is_64 && !is_io, "R3 pair size", size, 64'h1000_0000);
    chk(n_log == 8, "R3 access count", n_log, 8);
    chk_log(0, 0, 1, 0, "R3 save lo");
    chk_log(1, 0, 2, 0, "R3 save hi");
    chk_log(2, 1, 1, 32'hFFFF_FFFF, "R3 ones lo");
    chk_log(3, 1, 2, 32'hFFFF_FFFF, "R3 ones hi");
    chk_log(4, 0, 1, 0, "R3 read lo");
    chk_log(5, 0, 2, 0, "R3 read hi");
    chk_log(6, 1, 1, 32'hA000_000C, "R3 restore lo");
    chk_log(7, 1, 2, 32'h0, "R3 restore hi");
    chk(bar_val[1] == bar_init[1] && bar_val[2] == bar_init[2], "R8 pair restored",
        {bar_val[1], bar_val[2]}, {bar_init[1], bar_init[2]});
  endtask

  task automatic t_io();
    run_probe(3, 1);
    chk(is_io && !is_64 && size == 64'h80, "R5 io size", size, 64'h80);
    chk(bar_val[3] == 32'h0000_D001, "R8 io restored", bar_val[3], 32'h0000_D001);
  endtask

  task automatic t_unimpl();
    run_probe(4, 0);
    chk(unimpl && size == 0, "R6 unimplemented", {unimpl, size[62:0]}, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_big64();
    run_probe(5, 0);
    chk(is_64 && size == 64'h2_0000_0000, "R4 8GB pair size", size, 64'h2_0000_0000);
    chk($countones(size) == 1, "R10 power of two", size, 64'h2_0000_0000);
    chk(bar_val[6] == bar_init[6], "R8 hi restored", bar_val[6], bar_init[6]);
  endtask

  task automatic t_busy_start();
    int extra;
    lat = 3; n_log = 0;
    @(negedge clk); start = 1'b1; start_idx = 3'd0;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; start_idx = 3'd3;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 300 && !done; i++) @(negedge clk);
    chk(size == 64'h0100_0000 && !is_io, "R9 first run kept", size, 64'h0100_0000);
    chk(n_log == 4 && lg_idx[0] == 0 && lg_idx[3] == 0, "R9 no index switch", n_log, 4);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cfg_req || busy) extra++;
    end
    chk(extra == 0, "R9 no second run", extra, 0);
    chk(viol == 0, "R7 request held until ack", viol, 0);
  endtask

  initial begin
    cfg_ack = 1'b0; cfg_rdata = '0;
    init_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mem32();
    t_mem64();
    t_io();
    t_unimpl();
    t_big64();
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule